// File: doc/BRIEF.md
# Byte-Wide Serial Transceiver with Sticky Interrupt Flags

This block is a serial port for a small 8-bit processor system. The processor sees it as four byte registers selected by a two-bit address. One register moves bytes in both directions, one reports and clears status, and two hold the halves of a 16-bit baud divisor. The block sends and receives frames of one start bit, eight data bits with the least significant bit first, and one stop bit. The serial line idles high.

A write to the data register starts a frame at once, provided the transmitter is idle. The receiver samples the line at sixteen times the bit rate. It confirms a start bit half a bit after the falling edge and then samples each later bit at its centre. A received byte stays in a one-byte buffer until the next byte replaces it.

Two sticky flags record events. One flag marks a completed reception and the other marks a completed transmission. Software clears a flag by writing a one to its bit. The two flags are ORed onto a single interrupt line. Software can therefore feed the next byte from the transmit interrupt and collect each incoming byte from the receive interrupt. The transmit pin can be tied to the receive pin to loop bytes back.

Top module: `sio_port`

## Requirements
- R1: After reset the status register (offset 1) reads 0x01 (transmitter ready, everything else clear). irq is low, ser_tx is high, and offsets 2 and 3 read the low and high bytes of DIV_RST (default 26, so 0x1A and 0x00).
- R2: Offsets 2 and 3 are the low and high bytes of the baud divisor, and they read back what was written. One bit lasts 16*(divisor+1) clock cycles.
- R3: A transmitted frame is, in order, a start bit at 0, data bits 0 to 7, and a stop bit at 1. ser_tx is high whenever the transmitter is idle.
- R4: A write to offset 0 while status bit 0 is 1 starts a frame on the next cycle, and bit 0 stays 0 until the stop bit has fully been sent. A write to offset 0 while bit 0 is 0 is ignored.
- R5: Status bit 4, the transmit flag, becomes 1 when a stop bit finishes. It stays at 1 until it is cleared.
- R6: When a frame with a high stop bit arrives, its byte becomes readable at offset 0, and status bit 1 (data ready) and status bit 5 (receive flag) become 1. A read of offset 0 clears bit 1 and leaves bit 5 unchanged.
- R7: A write to offset 1 clears bit 5 if data bit 5 is 1 and clears bit 4 if data bit 4 is 1. Zero bits and all other bit positions in the written value have no effect.
- R8: If a flag's setting event and a write-one-to-clear of that flag fall in the same cycle, the flag becomes 1. A data read that coincides with a reception leaves bit 1 at 1.
- R9: irq is 1 exactly when status bit 5 or status bit 4 is 1.
- R10: A low pulse on ser_rx shorter than half a bit does not start a reception. Bits 1 and 5 stay 0.
- R11: A frame whose stop bit is low is discarded and leaves bits 1 and 5 unchanged. The receiver waits for the line to return high and then accepts the next frame normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 divisor low, 3 divisor high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of offset 0 consumes the received byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request, receive flag OR transmit flag |

## Verification
The hard coincidence is a receive flag being set in the same cycle that software writes a one to clear it. The bench provokes it by holding a status write of 0x20 on the bus for every cycle of an incoming frame, so the completion cycle must overlap a clear. Set-priority is judged at the ports. irq must be high for exactly one cycle, the byte must still be readable, and data ready must still be set. A design in which the clear wins never raises irq.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam logic [1:0] REG_DATA  = 2'd0;
    localparam logic [1:0] REG_STAT  = 2'd1;
    localparam logic [1:0] REG_DIVLO = 2'd2;
    localparam logic [1:0] REG_DIVHI = 2'd3;

    localparam int ST_TXRDY = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_TXIRQ = 4;
    localparam int ST_RXIRQ = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              line,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(OVS);
    localparam int BIT_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] shreg;
        logic [BIT_W-1:0]      bitcnt;
        logic [CNT_W-1:0]      ovs;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy   = 1'b1;
                r_d.shreg  = {1'b1, data, 1'b0};
                r_d.bitcnt = '0;
                r_d.ovs    = '0;
            end
        end else if (tick) begin
            r_d.ovs = r_q.ovs + 1'b1;
            if (r_q.ovs == CNT_W'(OVS - 1)) begin
                r_d.ovs   = '0;
                r_d.shreg = {1'b1, r_q.shreg[FRAME_BITS-1:1]};
                if (r_q.bitcnt == BIT_W'(FRAME_BITS - 1)) begin
                    r_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    r_d.bitcnt = r_q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{busy: 1'b0, shreg: '1, bitcnt: '0, ovs: '0};
        else        r_q <= r_d;
    end

    assign line = r_q.busy ? r_q.shreg[0] : 1'b1;
    assign busy = r_q.busy;

endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic [DATA_W-1:0] byte_o,
    output logic              done
);

    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [CNT_W-1:0]  ovs;
        logic [BIT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     rx_s;

    always_comb begin
        rx_s     = r_q.sync[1];
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], line};
        done     = 1'b0;
        unique case (r_q.st)
            RX_IDLE: begin
                if (!rx_s) begin
                    r_d.st  = RX_START;
                    r_d.ovs = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    r_d.ovs = r_q.ovs + 1'b1;
                    if (r_q.ovs == CNT_W'(OVS / 2 - 1)) begin
                        r_d.ovs    = '0;
                        r_d.bitcnt = '0;
                        r_d.st     = rx_s ? RX_IDLE : RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    r_d.ovs = r_q.ovs + 1'b1;
                    if (r_q.ovs == CNT_W'(OVS - 1)) begin
                        r_d.ovs   = '0;
                        r_d.shreg = {rx_s, r_q.shreg[DATA_W-1:1]};
                        if (r_q.bitcnt == BIT_W'(DATA_W - 1)) r_d.st = RX_STOP;
                        else r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    r_d.ovs = r_q.ovs + 1'b1;
                    if (r_q.ovs == CNT_W'(OVS - 1)) begin
                        r_d.ovs = '0;
                        done    = rx_s;
                        r_d.st  = rx_s ? RX_IDLE : RX_WAITHI;
                    end
                end
            end
            RX_WAITHI: begin
                if (rx_s) r_d.st = RX_IDLE;
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{sync: 2'b11, st: RX_IDLE, ovs: '0, bitcnt: '0, shreg: '0};
        else        r_q <= r_d;
    end

    assign byte_o = r_q.shreg;

endmodule

// File: rtl/sio_port.sv
module sio_port import sio_pkg::*; #(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int DIV_RST = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ser_tx,
    input  logic              ser_rx,
    output logic              irq
);

    localparam int DIV_W = 2 * DATA_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_rdy;
        logic              rx_flag;
        logic              tx_flag;
    } port_regs_t;

    port_regs_t        r_d, r_q;
    logic              tick, tx_busy, tx_done, rx_done, tx_start;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_flag, tx_flag, rx_rdy, tx_ready;
    logic [DATA_W-1:0] status;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(r_q.div), .tick(tick)
    );

    sio_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .data(bus_wdata), .line(ser_tx), .busy(tx_busy), .done(tx_done)
    );

    sio_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(ser_rx),
        .byte_o(rx_byte), .done(rx_done)
    );

    assign tx_start = bus_wr && (bus_addr == REG_DATA);

    always_comb begin
        r_d = r_q;
        if (bus_wr && bus_addr == REG_DIVLO) r_d.div[DATA_W-1:0]     = bus_wdata;
        if (bus_wr && bus_addr == REG_DIVHI) r_d.div[DIV_W-1:DATA_W] = bus_wdata;
        if (bus_wr && bus_addr == REG_STAT) begin
            if (bus_wdata[ST_RXIRQ]) r_d.rx_flag = 1'b0;
            if (bus_wdata[ST_TXIRQ]) r_d.tx_flag = 1'b0;
        end
        if (bus_rd && bus_addr == REG_DATA) r_d.rx_rdy = 1'b0;
        // event set wins over a same-cycle clear
        if (rx_done) begin
            r_d.rx_buf  = rx_byte;
            r_d.rx_rdy  = 1'b1;
            r_d.rx_flag = 1'b1;
        end
        if (tx_done) r_d.tx_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{div: DIV_W'(DIV_RST), rx_buf: '0, rx_rdy: 1'b0,
                             rx_flag: 1'b0, tx_flag: 1'b0};
        else        r_q <= r_d;
    end

    assign rx_flag  = r_q.rx_flag;
    assign tx_flag  = r_q.tx_flag;
    assign rx_rdy   = r_q.rx_rdy;
    assign tx_ready = !tx_busy;

    always_comb begin
        status           = '0;
        status[ST_TXRDY] = tx_ready;
        status[ST_RXRDY] = rx_rdy;
        status[ST_TXIRQ] = tx_flag;
        status[ST_RXIRQ] = rx_flag;
        unique case (bus_addr)
            REG_DATA:  bus_rdata = r_q.rx_buf;
            REG_STAT:  bus_rdata = status;
            REG_DIVLO: bus_rdata = r_q.div[DATA_W-1:0];
            default:   bus_rdata = r_q.div[DIV_W-1:DATA_W];
        endcase
    end

    assign irq = rx_flag | tx_flag;

endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ser_tx,
    input logic              irq,
    input logic              tx_done,
    input logic              tx_ready,
    input logic              tx_flag,
    input logic              rx_done,
    input logic              rx_flag,
    input logic              rx_rdy,
    input logic [DATA_W-1:0] rx_byte,
    input logic [DATA_W-1:0] rx_buf
);

    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ser_tx);

    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && tx_ready) |=> !tx_ready && !ser_tx);

    a_r5_tx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> tx_flag && tx_ready);

    a_r6_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_flag && rx_rdy && (rx_buf == $past(rx_byte)));

    a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[5] && !rx_done) |=> !rx_flag);

    a_r7_rx_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !bus_wdata[5] && rx_flag) |=> rx_flag);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_done || tx_done));

endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ser_tx(ser_tx), .irq(irq),
    .tx_done(tx_done), .tx_ready(tx_ready), .tx_flag(tx_flag),
    .rx_done(rx_done), .rx_flag(rx_flag), .rx_rdy(rx_rdy),
    .rx_byte(rx_byte), .rx_buf(r_q.rx_buf)
);

// File: tb/tb_sio_port.sv
module tb_sio_port;

    localparam int BITCLK = 64; // divisor 3 -> 16*4 clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_tx, irq;
    logic       loop_en = 1'b0;
    logic       drv_rx = 1'b1;
    logic       ser_rx;
    int         checks = 0;
    int         errors = 0;

    assign ser_rx = loop_en ? ser_tx : drv_rx;

    always #2.5 clk = ~clk;

    sio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_tx_idle(output int cyc);
        bus_addr = 2'd1;
        cyc = 0;
        #1;
        while (!bus_rdata[0] && cyc < 5000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        drv_rx = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rx = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        drv_rx = stop;
        repeat (BITCLK) @(negedge clk);
        drv_rx = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(2'd1, d); chk(d == 8'h01, "R1 status", d, 8'h01);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(ser_tx == 1'b1, "R1 ser_tx", ser_tx, 1);
        bus_read(2'd2, d); chk(d == 8'h1A, "R1 div low", d, 8'h1A);
        bus_read(2'd3, d); chk(d == 8'h00, "R1 div high", d, 8'h00);
    endtask

    task automatic t_divisor();
        logic [7:0] d;
        bus_write(2'd3, 8'h12);
        bus_read(2'd3, d); chk(d == 8'h12, "R2 div high readback", d, 8'h12);
        bus_write(2'd3, 8'h00);
        bus_write(2'd2, 8'h03);
        bus_read(2'd2, d); chk(d == 8'h03, "R2 div low readback", d, 8'h03);
        bus_read(2'd3, d); chk(d == 8'h00, "R2 div high cleared", d, 8'h00);
    endtask

    task automatic t_frame();
        logic [7:0] b = 8'h4D;
        logic [9:0] exp_bits;
        exp_bits = {1'b1, b, 1'b0};
        bus_write(2'd0, b);
        repeat (31) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            chk(ser_tx == exp_bits[i], $sformatf("R3 frame bit %0d", i), ser_tx, exp_bits[i]);
            repeat (BITCLK) @(negedge clk);
        end
        bus_write(2'd1, 8'h30);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_loopback();
        logic [7:0] d;
        int cyc;
        loop_en = 1'b1;
        bus_write(2'd0, 8'hA5);
        bus_read(2'd1, d); chk(d[0] == 1'b0, "R4 busy after write", d, 8'h00);
        wait_tx_idle(cyc);
        cyc = cyc + 2;
        chk(cyc >= 632 && cyc <= 648, "R2 frame length", cyc, 10 * BITCLK);
        bus_read(2'd1, d); chk(d == 8'h33, "R5 R6 flags after frame", d, 8'h33);
        chk(irq == 1'b1, "R9 irq with flags", irq, 1);
        bus_read(2'd0, d); chk(d == 8'hA5, "R6 loopback byte", d, 8'hA5);
        bus_read(2'd1, d); chk(d == 8'h31, "R6 read clears ready only", d, 8'h31);
        bus_write(2'd1, 8'h10);
        bus_read(2'd1, d); chk(d == 8'h21, "R7 clear tx flag", d, 8'h21);
        chk(irq == 1'b1, "R9 irq with rx flag", irq, 1);
        bus_write(2'd1, 8'hCF);
        bus_read(2'd1, d); chk(d == 8'h21, "R7 other bits ignored", d, 8'h21);
        bus_write(2'd1, 8'h20);
        bus_read(2'd1, d); chk(d == 8'h01, "R7 clear rx flag", d, 8'h01);
        chk(irq == 1'b0, "R9 irq low", irq, 0);
    endtask

    task automatic t_busy_write();
        logic [7:0] d;
        int cyc;
        bus_write(2'd0, 8'h3C);
        repeat (100) @(negedge clk);
        bus_write(2'd0, 8'hC3);
        wait_tx_idle(cyc);
        bus_read(2'd0, d); chk(d == 8'h3C, "R4 first byte", d, 8'h3C);
        repeat (12 * BITCLK) @(negedge clk);
        bus_read(2'd1, d); chk(d == 8'h31, "R4 write while busy ignored", d, 8'h31);
        bus_write(2'd1, 8'h30);
        loop_en = 1'b0;
    endtask

    task automatic t_direct_rx();
        logic [7:0] d;
        send_byte(8'h96, 1'b1);
        repeat (BITCLK) @(negedge clk);
        bus_read(2'd1, d); chk(d == 8'h23, "R6 direct rx status", d, 8'h23);
        bus_read(2'd0, d); chk(d == 8'h96, "R6 direct rx byte", d, 8'h96);
        bus_write(2'd1, 8'h20);
    endtask

    task automatic t_glitch();
        logic [7:0] d;
        drv_rx = 1'b0;
        repeat (BITCLK / 4) @(negedge clk);
        drv_rx = 1'b1;
        repeat (12 * BITCLK) @(negedge clk);
        bus_read(2'd1, d); chk(d == 8'h01, "R10 glitch rejected", d, 8'h01);
    endtask

    task automatic t_bad_stop();
        logic [7:0] d;
        send_byte(8'h55, 1'b0);
        repeat (12 * BITCLK) @(negedge clk);
        bus_read(2'd1, d); chk(d == 8'h01, "R11 bad stop discarded", d, 8'h01);
        send_byte(8'h11, 1'b1);
        repeat (BITCLK) @(negedge clk);
        bus_read(2'd0, d); chk(d == 8'h11, "R11 next frame received", d, 8'h11);
        bus_write(2'd1, 8'h20);
    endtask

    task automatic t_set_vs_clear();
        logic [7:0] d;
        int hi = 0;
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h20; bus_wr = 1'b1;
        fork
            send_byte(8'h7E, 1'b1);
            begin
                repeat (11 * BITCLK) begin
                    @(negedge clk);
                    if (irq) hi++;
                end
            end
        join
        bus_wr = 1'b0;
        chk(hi == 1, "R8 flag set wins for one cycle", hi, 1);
        bus_read(2'd1, d); chk(d == 8'h03, "R8 ready kept, flag cleared", d, 8'h03);
        bus_read(2'd0, d); chk(d == 8'h7E, "R8 byte kept", d, 8'h7E);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divisor();
        t_frame();
        t_loopback();
        t_busy_write();
        t_direct_rx();
        t_glitch();
        t_bad_stop();
        t_set_vs_clear();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        finish_run();
    end

endmodule